// File: doc/BRIEF.md
# Sector Protect Pulse Sequencer

This block is a host-side controller that runs the pulse-and-verify loop used to protect one sector group of a parallel NOR flash. It can also unprotect the whole array. The host raises `start_i` for one cycle. `unprot_i` selects the operation and `grp_sel_i` names the target group for a protect. The sequencer then drives command writes and status reads through a simple memory-bus master port with a fixed read latency of one cycle. It raises a single high-voltage request flag for the duration of the run. At the end it reports a pass or fail verdict.

Each attempt starts with a setup write. The sequencer then waits a programmable pulse interval, writes the verify command and reads the status back from the same address. A protect attempt passes when the status reports the group as locked. An unprotect attempt passes when the status reports it as open. A failed attempt advances a pulse counter, and reaching the ceiling ends the run with a fail.

Unprotect acts on every group at once, so the block first protects each group in ascending order, with a fresh counter per group. It then applies unprotect pulses and walks the verify through the groups. The pulse intervals are counter parameters in clock cycles.

Top module: `sgp_sequencer`

## Requirements
- R1: While reset is held and after it is released with no start, `busy_o`, `done_o`, `pass_o`, `fail_o`, `hv_o`, `bus_we_o` and `bus_re_o` are all low.
- R2: A start is accepted only while `busy_o` is low. `busy_o` rises in the next cycle. A start raised while busy changes neither the operation, nor the group, nor the result.
- R3: Every attempt begins with a write of 60h. The address carries the group number in its bits from `GROUP_SHIFT` upward and a low seven-bit pattern: 0000010 for protect, 1000010 for unprotect. All other address bits are zero. Every write carries either 60h or 40h.
- R4: Between a 60h write and the following 40h write there are exactly `PROT_CYCLES` idle bus cycles for protect, or `UNPROT_CYCLES` for unprotect.
- R5: A verify is a 40h write followed in the next cycle by a read at the same address. The status is taken from `bus_rdata_i` in the cycle after the read strobe.
- R6: Only status bit 0 is used. A protect verify passes when it is 1, and an unprotect verify passes when it is 0.
- R7: The pulse counter starts at 1 and is incremented after each failed verify. When it reaches `MAX_PULSES`, the run ends in fail. So at most `MAX_PULSES`-1 setup writes are made per group in a protect, and per unprotect phase.
- R8: In an unprotect run, groups 0 to last are first protected in ascending order, each with the counter restarted at 1. A protect failure ends the run in fail with no unprotect pulse.
- R9: The unprotect phase starts its counter at 1 and shares it across groups. After a pulse, groups are verified in ascending order. A passing group moves on to the next without a new pulse. A failing group gets a new pulse and is verified again.
- R10: `done_o` is high for one cycle, with exactly one of `pass_o` and `fail_o` set. The verdict holds until the next accepted start. `busy_o` is high from the cycle after start through the done cycle.
- R11: `hv_o` is high from the cycle after start up to the cycle before `done_o`, and low otherwise.
- R12: The write and read strobes are never high together, and are only high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| unprot_i | input | 1 | 1 = unprotect all groups, 0 = protect one group |
| grp_sel_i | input | ADDR_W-GROUP_SHIFT | Group to protect |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | DATA_W | Read data, valid one cycle after read strobe |
| hv_o | output | 1 | High-voltage request flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| pass_o | output | 1 | Operation succeeded |
| fail_o | output | 1 | Operation failed |

## Verification
Two events can fall on the same verify cycle. One is the verdict on the last allowed attempt; the other is the ceiling check. The bench sweeps the number of pulses the modelled cell needs across the ceiling, so the final attempt both passes (need = `MAX_PULSES`-1) and fails (need = `MAX_PULSES`). It then judges the verdict and the exact setup-write count. A start request is also raised mid-run with the other mode and another group. This start lands alongside the running sequence, and the bench checks that the bus addresses and the result match an undisturbed run.

// File: rtl/sgp_pkg.sv
`timescale 1ns/1ps
package sgp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PULSE, ST_WAIT, ST_VWR, ST_VRD, ST_VCHK, ST_DONE
  } sgp_state_e;

  typedef enum logic {PH_PROT, PH_UNPROT} sgp_phase_e;

  localparam logic [7:0] OP_SETUP  = 8'h60;
  localparam logic [7:0] OP_VERIFY = 8'h40;
  localparam int unsigned PAT_W = 7;
  localparam logic [PAT_W-1:0] PAT_PROT   = 7'b0000010;
  localparam logic [PAT_W-1:0] PAT_UNPROT = 7'b1000010;
endpackage

// File: rtl/sgp_wait_timer.sv
`timescale 1ns/1ps
module sgp_wait_timer #(
  parameter int unsigned PROT_CYCLES   = 15000,
  parameter int unsigned UNPROT_CYCLES = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned MAX_C = (UNPROT_CYCLES > PROT_CYCLES) ? UNPROT_CYCLES : PROT_CYCLES;
  localparam int unsigned CW    = $clog2(MAX_C + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= long_i ? CW'(UNPROT_CYCLES - 1) : CW'(PROT_CYCLES - 1);
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sgp_pulse_counter.sv
`timescale 1ns/1ps
module sgp_pulse_counter #(
  parameter int unsigned MAX_PULSES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(1);
    end else if (clr_i) begin
      cnt_q <= CW'(1);
    end else if (inc_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // one more failure would reach the ceiling
  assign last_o = (cnt_q == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/sgp_addr_gen.sv
`timescale 1ns/1ps
module sgp_addr_gen
  import sgp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 21,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned GROUP_SHIFT = 15,
  localparam int unsigned GRP_W      = ADDR_W - GROUP_SHIFT
) (
  input  logic [GRP_W-1:0]  grp_i,
  input  logic              unprot_i,
  input  logic              verify_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int unsigned FILL_W = GROUP_SHIFT - PAT_W;

  logic [PAT_W-1:0] pat;
  assign pat = unprot_i ? PAT_UNPROT : PAT_PROT;

  generate
    if (FILL_W > 0) begin : g_fill
      assign addr_o = {grp_i, {FILL_W{1'b0}}, pat};
    end else begin : g_nofill
      assign addr_o = {grp_i, pat};
    end
  endgenerate

  assign wdata_o = verify_i ? DATA_W'(OP_VERIFY) : DATA_W'(OP_SETUP);
endmodule

// File: rtl/sgp_sequencer.sv
`timescale 1ns/1ps
module sgp_sequencer
  import sgp_pkg::*;
#(
  parameter int unsigned ADDR_W        = 21,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned GROUP_SHIFT   = 15,
  parameter int unsigned MAX_PULSES    = 1000,
  parameter int unsigned PROT_CYCLES   = 15000,
  parameter int unsigned UNPROT_CYCLES = 1500000,
  localparam int unsigned GRP_W        = ADDR_W - GROUP_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              unprot_i,
  input  logic [GRP_W-1:0]  grp_sel_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              hv_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam logic [GRP_W-1:0] LAST_GRP = {GRP_W{1'b1}};

  sgp_state_e       state_q, state_d;
  sgp_phase_e       phase_q, phase_d;
  logic             mode_q, mode_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             pass_q, pass_d, fail_q, fail_d;
  logic             cnt_clr, cnt_inc, cnt_last;
  logic             tmr_load, tmr_expired;
  logic             status_ok;
  logic             unused_rdata;

  assign unused_rdata = ^bus_rdata_i[DATA_W-1:1];

  sgp_wait_timer #(
    .PROT_CYCLES  (PROT_CYCLES),
    .UNPROT_CYCLES(UNPROT_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .long_i   (phase_q == PH_UNPROT),
    .run_i    (state_q == ST_WAIT),
    .expired_o(tmr_expired)
  );

  sgp_pulse_counter #(
    .MAX_PULSES(MAX_PULSES)
  ) u_pulses (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .last_o(cnt_last)
  );

  sgp_addr_gen #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .GROUP_SHIFT(GROUP_SHIFT)
  ) u_addr (
    .grp_i   (grp_q),
    .unprot_i(phase_q == PH_UNPROT),
    .verify_i(state_q != ST_PULSE),
    .addr_o  (bus_addr_o),
    .wdata_o (bus_wdata_o)
  );

  // locked group reads 1, open group reads 0
  assign status_ok = (phase_q == PH_PROT) ? bus_rdata_i[0] : ~bus_rdata_i[0];

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    mode_d   = mode_q;
    grp_d    = grp_q;
    pass_d   = pass_q;
    fail_d   = fail_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d  = unprot_i;
          phase_d = PH_PROT;
          grp_d   = unprot_i ? '0 : grp_sel_i;
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          cnt_clr = 1'b1;
          state_d = ST_PULSE;
        end
      end
      ST_PULSE: begin
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (tmr_expired) state_d = ST_VWR;
      end
      ST_VWR: state_d = ST_VRD;
      ST_VRD: state_d = ST_VCHK;
      ST_VCHK: begin
        if (status_ok) begin
          if (phase_q == PH_PROT) begin
            if (!mode_q) begin
              pass_d  = 1'b1;
              state_d = ST_DONE;
            end else if (grp_q == LAST_GRP) begin
              phase_d = PH_UNPROT;
              grp_d   = '0;
              cnt_clr = 1'b1;
              state_d = ST_PULSE;
            end else begin
              grp_d   = grp_q + GRP_W'(1);
              cnt_clr = 1'b1;
              state_d = ST_PULSE;
            end
          end else if (grp_q == LAST_GRP) begin
            pass_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            // open group: verify the next one without a new pulse
            grp_d   = grp_q + GRP_W'(1);
            state_d = ST_VWR;
          end
        end else if (cnt_last) begin
          fail_d  = 1'b1;
          state_d = ST_DONE;
        end else begin
          cnt_inc = 1'b1;
          state_d = ST_PULSE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_PROT;
      mode_q  <= 1'b0;
      grp_q   <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
      grp_q   <= grp_d;
      pass_q  <= pass_d;
      fail_q  <= fail_d;
    end
  end

  assign bus_we_o = (state_q == ST_PULSE) || (state_q == ST_VWR);
  assign bus_re_o = (state_q == ST_VRD);
  assign busy_o   = (state_q != ST_IDLE);
  assign hv_o     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_o   = (state_q == ST_DONE);
  assign pass_o   = pass_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/sgp_sequencer_chk.sv
`timescale 1ns/1ps
module sgp_sequencer_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_we_o,
  input logic              bus_re_o,
  input logic              hv_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o
);
  localparam logic [DATA_W-1:0] SETUP  = DATA_W'(8'h60);
  localparam logic [DATA_W-1:0] VERIFY = DATA_W'(8'h40);

  assert_one_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_re_o));

  assert_strobe_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_re_o) |-> busy_o);

  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));

  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && !done_o) |=> busy_o);

  assert_opcode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (bus_wdata_o == SETUP || bus_wdata_o == VERIFY));

  assert_low_pattern_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (bus_addr_o[5:0] == 6'b000010));

  assert_pulse_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_wdata_o == SETUP) |=> (!bus_we_o && !bus_re_o));

  assert_read_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_o |-> ($past(bus_we_o) && $past(bus_wdata_o) == VERIFY && $stable(bus_addr_o)));

  assert_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o ^ fail_o));

  assert_done_once_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_hv_window_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_o |-> (busy_o && !done_o));

  assert_hv_before_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(hv_o));
endmodule

bind sgp_sequencer sgp_sequencer_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .bus_addr_o (bus_addr_o),
  .bus_wdata_o(bus_wdata_o),
  .bus_we_o   (bus_we_o),
  .bus_re_o   (bus_re_o),
  .hv_o       (hv_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/sgp_sequencer_tb_top.sv
`timescale 1ns/1ps
module sgp_sequencer_tb_top;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int GS    = 8;
  localparam int GW    = AW - GS;
  localparam int NG    = 1 << GW;
  localparam int MAXP  = 5;
  localparam int PROTW = 6;
  localparam int UNPW  = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          unprot_i = 1'b0;
  logic [GW-1:0] grp_sel_i = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_we, bus_re;
  logic [DW-1:0] bus_rdata = '0;
  logic          hv, busy, done, pass_s, fail_s;

  always #2.5 clk = ~clk;

  sgp_sequencer #(
    .ADDR_W(AW), .DATA_W(DW), .GROUP_SHIFT(GS), .MAX_PULSES(MAXP),
    .PROT_CYCLES(PROTW), .UNPROT_CYCLES(UNPW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .unprot_i(unprot_i),
    .grp_sel_i(grp_sel_i), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_we_o(bus_we), .bus_re_o(bus_re), .bus_rdata_i(bus_rdata),
    .hv_o(hv), .busy_o(busy), .done_o(done), .pass_o(pass_s), .fail_o(fail_s)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash status model
  int prot_need[NG];
  int unp_need[NG];
  int prot_cnt[NG];
  int unp_cnt, n_verify, n_unp_setup, order_err, last_prot_g;
  int cyc = 0, last_setup_cyc, last_vwr_cyc;
  bit last_was_setup, last_setup_unp;
  logic [AW-1:0] last_vwr_addr;

  task automatic clear_model();
    for (int g = 0; g < NG; g++) begin
      prot_need[g] = 1; unp_need[g] = 1; prot_cnt[g] = 0;
    end
    unp_cnt = 0; n_verify = 0; n_unp_setup = 0; order_err = 0; last_prot_g = 0;
    last_was_setup = 0; last_vwr_cyc = -10;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_we) begin
        int g;
        g = int'(bus_addr >> GS);
        if (bus_wdata == 8'h60) begin
          chk(bus_addr[5:0] == 6'b000010 && bus_addr[7] == 1'b0, "R3 setup address", int'(bus_addr), 2);
          if (bus_addr[6]) begin
            unp_cnt++; n_unp_setup++;
          end else begin
            if (unp_cnt > 0 || g < last_prot_g) order_err++;
            last_prot_g = g;
            prot_cnt[g]++;
          end
          last_setup_cyc = cyc; last_was_setup = 1; last_setup_unp = bus_addr[6];
        end else begin
          chk(bus_wdata == 8'h40, "R3 write opcode", int'(bus_wdata), 8'h40);
          n_verify++;
          if (last_was_setup)
            chk(cyc - last_setup_cyc - 1 == (last_setup_unp ? UNPW : PROTW), "R4 pulse gap",
                cyc - last_setup_cyc - 1, last_setup_unp ? UNPW : PROTW);
          last_was_setup = 0; last_vwr_cyc = cyc; last_vwr_addr = bus_addr;
        end
      end
      if (bus_re) begin
        int g;
        bit st;
        g = int'(bus_addr >> GS);
        chk(last_vwr_cyc == cyc - 1 && last_vwr_addr == bus_addr, "R5 read after verify",
            int'(bus_addr), int'(last_vwr_addr));
        st = (unp_cnt > 0) ? (unp_cnt < unp_need[g]) : (prot_cnt[g] >= prot_need[g]);
        bus_rdata = {7'b1010101, st}; // R6: upper bits are noise
      end
    end
  end

  bit got_pass, got_fail;

  task automatic run_op(input bit unp, input int grp, input int glitch_at);
    int t;
    @(negedge clk);
    start_i = 1'b1; unprot_i = unp; grp_sel_i = GW'(grp);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy && !done, "R2 start accepted", int'(busy), 1);
    chk(hv, "R11 hv raised", int'(hv), 1);
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
      start_i = (t == glitch_at);
      unprot_i = (t == glitch_at) ? ~unp : unp;
      grp_sel_i = (t == glitch_at) ? GW'(grp + 1) : GW'(grp);
    end
    start_i = 1'b0;
    chk(done, "R10 completion seen", int'(done), 1);
    chk(!hv, "R11 hv low at done", int'(hv), 0);
    got_pass = pass_s; got_fail = fail_s;
    chk(pass_s ^ fail_s, "R10 single verdict", int'({pass_s, fail_s}), 1);
    @(negedge clk);
    chk(!busy && !done, "R10 back to idle", int'(busy), 0);
    chk(pass_s == got_pass && fail_s == got_fail, "R10 verdict held", int'(pass_s), int'(got_pass));
  endtask

  function automatic int min_i(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // verifies issued during the unprotect phase for lim pulses
  function automatic int unp_verifies(int lim);
    int cur = 0;
    int v = 0;
    for (int k = 1; k <= lim; k++) begin
      while (1) begin
        v++;
        if (unp_need[cur] <= k) begin
          if (cur == NG - 1) return v;
          cur++;
        end else break;
      end
    end
    return v;
  endfunction

  task automatic unprot_case(input int p0, p1, p2, p3, u0, u1, u2, u3);
    int fail_g, exp_v, umax, ulim;
    bit exp_pass;
    clear_model();
    prot_need[0] = p0; prot_need[1] = p1; prot_need[2] = p2; prot_need[3] = p3;
    unp_need[0] = u0; unp_need[1] = u1; unp_need[2] = u2; unp_need[3] = u3;
    fail_g = -1; exp_v = 0; umax = 0;
    for (int g = 0; g < NG; g++) begin
      if (fail_g < 0) begin
        exp_v += min_i(prot_need[g], MAXP - 1);
        if (prot_need[g] > MAXP - 1) fail_g = g;
      end
      if (unp_need[g] > umax) umax = unp_need[g];
    end
    ulim = min_i(umax, MAXP - 1);
    if (fail_g < 0) exp_v += unp_verifies(ulim);
    exp_pass = (fail_g < 0) && (umax <= MAXP - 1);
    run_op(1'b1, 0, 0);
    chk(got_pass == exp_pass, "R9 unprotect verdict", int'(got_pass), int'(exp_pass));
    for (int g = 0; g < NG; g++) begin
      int ep;
      ep = (fail_g >= 0 && g > fail_g) ? 0 : min_i(prot_need[g], MAXP - 1);
      chk(prot_cnt[g] == ep, "R8 protect pulses per group", prot_cnt[g], ep);
    end
    chk(order_err == 0, "R8 ascending protect order", order_err, 0);
    chk(n_unp_setup == ((fail_g >= 0) ? 0 : ulim), "R9 unprotect pulses", n_unp_setup,
        (fail_g >= 0) ? 0 : ulim);
    chk(n_verify == exp_v, "R9 verify count", n_verify, exp_v);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass_s && !fail_s && !hv && !bus_we && !bus_re, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !pass_s && !fail_s && !hv && !bus_we && !bus_re, "R1 after reset", int'(busy), 0);

    // R6 R7: protect sweep across groups and pulse needs
    for (int g = 0; g < NG; g++) begin
      for (int need = 1; need <= MAXP + 1; need++) begin
        int ep;
        bit expp;
        clear_model();
        prot_need[g] = need;
        ep = min_i(need, MAXP - 1);
        expp = (need <= MAXP - 1);
        run_op(1'b0, g, 0);
        chk(got_pass == expp, "R7 protect verdict", int'(got_pass), int'(expp));
        chk(got_fail == !expp, "R6 fail flag", int'(got_fail), int'(!expp));
        chk(prot_cnt[g] == ep, "R7 setup count", prot_cnt[g], ep);
        chk(n_verify == ep, "R5 verify count", n_verify, ep);
        chk(n_unp_setup == 0, "R3 no unprotect pattern", n_unp_setup, 0);
        for (int o = 0; o < NG; o++)
          if (o != g) chk(prot_cnt[o] == 0, "R3 group address", prot_cnt[o], 0);
      end
    end

    // R2: start raised mid-run with other mode and group
    for (int gl = 2; gl <= 20; gl += 9) begin
      clear_model();
      prot_need[2] = 3;
      run_op(1'b0, 2, gl);
      chk(got_pass, "R2 ignored start verdict", int'(got_pass), 1);
      chk(prot_cnt[2] == 3 && prot_cnt[3] == 0 && n_unp_setup == 0, "R2 ignored start traffic",
          prot_cnt[2], 3);
    end

    // R8 R9: unprotect scenarios
    unprot_case(1, 1, 1, 1, 1, 1, 1, 1);
    unprot_case(2, 3, 1, 4, 1, 3, 2, 2);
    unprot_case(1, 5, 1, 1, 1, 1, 1, 1);
    unprot_case(1, 1, 1, 1, 2, 1, 5, 1);
    unprot_case(4, 4, 4, 4, 4, 1, 1, 4);
    for (int u = 1; u <= MAXP + 1; u++) unprot_case(1, 2, 1, 1, 2, 1, 1, u);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule